// File: doc/BRIEF.md
# Two-Road Intersection Light Controller

This block sequences the lights of a crossing between a main road and a side road. The main road shows GREEN by default. The side road gets GREEN only when its car sensor asks for it. A single master state machine drives the main-road light and owns one shared green timer. A slave state machine drives the side-road light. The slave raises a request when a car waits at RED. The master answers with a grant in the cycle that it leaves GREEN. Later the master orders the slave back to RED, either when the shared timer runs out or when the waiting car is gone.

An emergency input overrides normal operation. It sends both roads to RED within two clocks and holds them there for a minimum time. The inputs are a clock, a synchronous active-low reset, the side-road sensor and the emergency sensor. The two light states are presented as a 3-bit enumeration. The green timer width is a parameter. With the default of 2 bits, the timer saturates at 3.

Top module: `tl_intersection`

## Requirements
- R1: While reset is sampled low, both lights read OFF on the following clock. On the first clock with reset high, the main light becomes GREEN and the side light becomes RED, with the shared timer at zero. If the emergency input is high on that clock, the main light becomes RED instead.
- R2: Light codes are 3 bits wide: OFF=0, RED=1, YELLOW=2, GREEN=3, PRE_GREEN=4.
- R3: The main light stays GREEN while neither input demands a change. With the side sensor held high, every main GREEN period lasts exactly four cycles, because the shared timer must count from 0 to its limit of 3 before a grant is given.
- R4: A YELLOW light of either road becomes RED on the next clock. No light moves from GREEN directly to RED.
- R5: A grant moves the main light to YELLOW and the side light to PRE_GREEN on the same clock. On the next clock the main light is RED and the side light is GREEN.
- R6: While the side sensor stays high, the side light is GREEN for exactly four cycles. It then shows YELLOW for one cycle and RED after that.
- R7: If the side sensor is low while the side light is GREEN and the shared timer is non-zero, the side light goes to YELLOW early. The side GREEN period therefore lasts 2 cycles at minimum.
- R8: The main light returns from RED to GREEN on the clock after the side light reads RED, provided the timer is at its limit and there is no emergency. The timer then restarts from 0.
- R9: When emergency is sampled high, both lights read RED two clocks later. The main light stays RED on the two clocks after that as well.
- R10: The two lights are never GREEN together. Neither light is GREEN while the other is YELLOW.
- R11: With the side sensor held high and no emergency, the side light turns GREEN within 11 clocks.
- R12: A side light in PRE_GREEN that sees the emergency input goes straight to RED instead of GREEN.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| sideSensor | input | 1 | Car waiting on the side road |
| emergency | input | 1 | Emergency vehicle present |
| mainLight | output | 3 | Main-road light state (light_e) |
| sideLight | output | 3 | Side-road light state (light_e) |

## Verification
Every light is a register, so an input applied between edges is seen in the light one clock later.

The bench drives inputs and samples outputs on falling edges. Each expected step number is derived from the arithmetic of the timer, counted from the first main GREEN:
- A sensor raised d cycles into a main GREEN period gives side GREEN after max(3,d)+2-d clocks.
- A sensor dropped k cycles into a side GREEN period gives a GREEN length of min(3,max(k,1))+1 cycles.
- An emergency pulse gives RED at +2, +3 and +4.

Sweeps over d, k and the emergency phase compare the lights at exactly those steps. A per-step monitor accumulates the mutual-exclusion, YELLOW-to-RED and wait-length rules.

// File: rtl/tl_pkg.sv
package tl_pkg;

  typedef enum logic [2:0] {
    LT_OFF      = 3'd0,
    LT_RED      = 3'd1,
    LT_YELLOW   = 3'd2,
    LT_GREEN    = 3'd3,
    LT_PREGREEN = 3'd4
  } light_e;

  // strobes from control to the timer datapath
  typedef struct packed {
    logic tmrClear;
  } tl_strobe_s;

endpackage

// File: rtl/tl_timer.sv
module tl_timer #(
  parameter int TIMER_W = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  tl_pkg::tl_strobe_s strobe,
  output logic [TIMER_W-1:0] count,
  output logic               atLimit
);
  localparam logic [TIMER_W-1:0] LIMIT = {TIMER_W{1'b1}};

  assign atLimit = (count == LIMIT);

  // saturating up-counter, cleared on request
  always_ff @(posedge clk) begin
    if (!rstN)                count <= '0;
    else if (strobe.tmrClear) count <= '0;
    else if (!atLimit)        count <= count + 1'b1;
  end
endmodule

// File: rtl/tl_ctrl.sv
module tl_ctrl #(
  parameter int TIMER_W = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sideSensor,
  input  logic               emergency,
  input  logic [TIMER_W-1:0] count,
  input  logic               atLimit,
  output tl_pkg::light_e     mainLight,
  output tl_pkg::light_e     sideLight,
  output tl_pkg::tl_strobe_s strobe
);
  import tl_pkg::*;

  light_e mainNext, sideNext;
  logic   sideReq, grant, toRed, mainToGreen;

  // handshake between master (main road) and slave (side road)
  always_comb begin
    sideReq     = (sideLight == LT_RED) && sideSensor;
    grant       = (mainLight == LT_GREEN) && sideReq && atLimit && !emergency;
    toRed       = (sideLight == LT_GREEN) &&
                  (emergency || atLimit || (!sideSensor && (count != '0)));
    mainToGreen = (mainLight == LT_RED) && (sideLight == LT_RED) &&
                  atLimit && !emergency;
    strobe.tmrClear = (mainLight == LT_OFF) || (mainLight == LT_YELLOW) ||
                      mainToGreen || emergency;
  end

  // master FSM
  always_comb begin
    case (mainLight)
      LT_OFF:    mainNext = emergency ? LT_RED : LT_GREEN;
      LT_GREEN:  mainNext = (emergency || grant) ? LT_YELLOW : LT_GREEN;
      LT_YELLOW: mainNext = LT_RED;
      LT_RED:    mainNext = mainToGreen ? LT_GREEN : LT_RED;
      default:   mainNext = LT_OFF;
    endcase
  end

  // slave FSM
  always_comb begin
    case (sideLight)
      LT_OFF:      sideNext = LT_RED;
      LT_RED:      sideNext = grant ? LT_PREGREEN : LT_RED;
      LT_PREGREEN: sideNext = emergency ? LT_RED : LT_GREEN;
      LT_GREEN:    sideNext = toRed ? LT_YELLOW : LT_GREEN;
      LT_YELLOW:   sideNext = LT_RED;
      default:     sideNext = LT_OFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mainLight <= LT_OFF;
      sideLight <= LT_OFF;
    end else begin
      mainLight <= mainNext;
      sideLight <= sideNext;
    end
  end
endmodule

// File: rtl/tl_intersection.sv
module tl_intersection #(
  parameter int TIMER_W = 2
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           sideSensor,
  input  logic           emergency,
  output tl_pkg::light_e mainLight,
  output tl_pkg::light_e sideLight
);
  tl_pkg::tl_strobe_s strobe;
  logic [TIMER_W-1:0] count;
  logic               atLimit;

  tl_timer #(.TIMER_W(TIMER_W)) u_timer (
    .clk(clk), .rstN(rstN), .strobe(strobe), .count(count), .atLimit(atLimit)
  );

  tl_ctrl #(.TIMER_W(TIMER_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .sideSensor(sideSensor), .emergency(emergency),
    .count(count), .atLimit(atLimit),
    .mainLight(mainLight), .sideLight(sideLight), .strobe(strobe)
  );
endmodule

// File: rtl/tl_intersection_chk.sv
module tl_intersection_chk #(
  parameter int LAT_LIMIT = 11
) (
  input logic           clk,
  input logic           rstN,
  input logic           sideSensor,
  input logic           emergency,
  input tl_pkg::light_e mainLight,
  input tl_pkg::light_e sideLight
);
  import tl_pkg::*;

  logic [7:0] waitCnt;
  always_ff @(posedge clk) begin
    if (!rstN || !sideSensor || emergency || sideLight == LT_GREEN) waitCnt <= '0;
    else if (waitCnt != 8'hFF) waitCnt <= waitCnt + 8'd1;
  end

  a_r1_reset_off: assert property (@(posedge clk)
    !rstN |=> (mainLight == LT_OFF && sideLight == LT_OFF));

  a_r10_no_dual_green: assert property (@(posedge clk) disable iff (!rstN)
    !(mainLight == LT_GREEN && sideLight == LT_GREEN));

  a_r10_no_green_yellow: assert property (@(posedge clk) disable iff (!rstN)
    !((mainLight == LT_GREEN && sideLight == LT_YELLOW) ||
      (sideLight == LT_GREEN && mainLight == LT_YELLOW)));

  a_r4_main_yellow_red: assert property (@(posedge clk) disable iff (!rstN)
    mainLight == LT_YELLOW |=> mainLight == LT_RED);

  a_r4_side_yellow_red: assert property (@(posedge clk) disable iff (!rstN)
    sideLight == LT_YELLOW |=> sideLight == LT_RED);

  a_r4_main_green_not_red: assert property (@(posedge clk) disable iff (!rstN)
    mainLight == LT_GREEN |=> mainLight != LT_RED);

  a_r3_green_holds: assert property (@(posedge clk) disable iff (!rstN)
    $rose(mainLight == LT_GREEN) && !emergency |=> mainLight == LT_GREEN);

  a_r5_pregreen_with_yellow: assert property (@(posedge clk) disable iff (!rstN)
    sideLight == LT_PREGREEN |-> mainLight == LT_YELLOW);

  a_r5_pregreen_to_green: assert property (@(posedge clk) disable iff (!rstN)
    sideLight == LT_PREGREEN && !emergency |=> sideLight == LT_GREEN);

  a_r12_pregreen_abort: assert property (@(posedge clk) disable iff (!rstN)
    sideLight == LT_PREGREEN && emergency |=> sideLight == LT_RED);

  a_r9_emergency_red: assert property (@(posedge clk) disable iff (!rstN)
    emergency |-> ##2 (mainLight == LT_RED && sideLight == LT_RED)
                  ##1 mainLight == LT_RED ##1 mainLight == LT_RED);

  a_r11_wait_bound: assert property (@(posedge clk) disable iff (!rstN)
    waitCnt <= 8'(LAT_LIMIT));
endmodule

bind tl_intersection tl_intersection_chk #(.LAT_LIMIT(11)) chk (
  .clk(clk), .rstN(rstN), .sideSensor(sideSensor), .emergency(emergency),
  .mainLight(mainLight), .sideLight(sideLight)
);

// File: tb/tl_intersection_test.sv
module tl_intersection_test;
  timeunit 1ns;
  timeprecision 1ps;
  import tl_pkg::*;

  logic   clk = 1'b0;
  logic   rstN = 1'b0;
  logic   sideSensor = 1'b0;
  logic   emergency = 1'b0;
  light_e mainLight, sideLight;

  int checks = 0;
  int errors = 0;
  int exclViol = 0;
  int yellowViol = 0;
  int waitCnt = 0;
  int maxWait = 0;
  bit done = 0;
  light_e prevMain = LT_OFF, prevSide = LT_OFF;

  localparam int RED = 1, YEL = 2, GRN = 3, PRE = 4, OFF = 0;

  tl_intersection uut (
    .clk(clk), .rstN(rstN), .sideSensor(sideSensor), .emergency(emergency),
    .mainLight(mainLight), .sideLight(sideLight)
  );

  always #10 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // advance to the next falling edge and update running monitors
  task automatic step();
    @(negedge clk);
    if (rstN) begin
      if ((mainLight == LT_GREEN && sideLight == LT_GREEN) ||
          (mainLight == LT_GREEN && sideLight == LT_YELLOW) ||
          (sideLight == LT_GREEN && mainLight == LT_YELLOW)) exclViol++;
      if ((prevMain == LT_YELLOW && mainLight != LT_RED) ||
          (prevSide == LT_YELLOW && sideLight != LT_RED) ||
          (prevMain == LT_GREEN && mainLight == LT_RED) ||
          (prevSide == LT_GREEN && sideLight == LT_RED)) yellowViol++;
      if (sideSensor && !emergency && sideLight != LT_GREEN) waitCnt++;
      else waitCnt = 0;
      if (waitCnt > maxWait) maxWait = waitCnt;
    end else waitCnt = 0;
    prevMain = mainLight;
    prevSide = sideLight;
  endtask

  task automatic resetDut();
    rstN = 1'b0; sideSensor = 1'b0; emergency = 1'b0;
    step(); step();
    chk("R1 main off in reset", int'(mainLight), OFF);
    chk("R1 side off in reset", int'(sideLight), OFF);
    rstN = 1'b1;
    step();
    chk("R1 main green after release", int'(mainLight), GRN);
    chk("R1 side red after release", int'(sideLight), RED);
  endtask

  initial begin
    // R2: code values
    chk("R2 code OFF", int'(LT_OFF), 0);
    chk("R2 code PRE_GREEN", int'(LT_PREGREEN), 4);

    // R1: emergency on release sends main to RED
    rstN = 1'b0; step(); step();
    rstN = 1'b1; emergency = 1'b1;
    step();
    emergency = 1'b0;
    chk("R1 main red on emergency release", int'(mainLight), RED);
    chk("R1 side red on emergency release", int'(sideLight), RED);

    // latency sweep: sensor raised d cycles into main GREEN
    for (int d = 0; d < 8; d++) begin
      int expLat;
      resetDut();
      repeat (d) step();
      sideSensor = 1'b1;
      expLat = ((d > 3) ? d : 3) + 2 - d;
      repeat (expLat - 1) step();
      chk("R5 main yellow at grant", int'(mainLight), YEL);
      chk("R5 side pregreen at grant", int'(sideLight), PRE);
      step();
      chk("R11 side green at computed latency", int'(sideLight), GRN);
      chk("R4 main red after yellow", int'(mainLight), RED);
      for (int i = 1; i < 4; i++) begin
        step();
        chk("R6 side green held", int'(sideLight), GRN);
      end
      step();
      chk("R6 side yellow after four", int'(sideLight), YEL);
      step();
      chk("R4 side red after yellow", int'(sideLight), RED);
      step();
      chk("R8 main back to green", int'(mainLight), GRN);
      repeat (3) step();
      chk("R3 main green fourth cycle", int'(mainLight), GRN);
      step();
      chk("R3 main yellow after four", int'(mainLight), YEL);
    end

    // early release sweep: sensor dropped k cycles into side GREEN
    for (int k = 0; k < 5; k++) begin
      int lenExp;
      resetDut();
      sideSensor = 1'b1;
      repeat (5) step();
      chk("R7 side green start", int'(sideLight), GRN);
      lenExp = ((k > 1 ? k : 1) < 3 ? (k > 1 ? k : 1) : 3) + 1;
      if (k == 0) sideSensor = 1'b0;
      for (int i = 1; i <= lenExp; i++) begin
        step();
        if (i < lenExp) chk("R7 side still green", int'(sideLight), GRN);
        else            chk("R7 side yellow at computed length", int'(sideLight), YEL);
        if (i == k) sideSensor = 1'b0;
      end
      sideSensor = 1'b0;
      step();
      chk("R4 side red after early yellow", int'(sideLight), RED);
      step();
      chk("R8 main green after side red", int'(mainLight), GRN);
      repeat (5) step();
      chk("R3 main green without demand", int'(mainLight), GRN);
      chk("R3 side red without demand", int'(sideLight), RED);
    end

    // emergency phase sweep with side sensor held
    for (int e = 0; e < 14; e++) begin
      int n;
      resetDut();
      sideSensor = 1'b1;
      repeat (e) step();
      emergency = 1'b1;
      step();
      emergency = 1'b0;
      if (e == 4) chk("R12 pregreen aborted to red", int'(sideLight), RED);
      step();
      chk("R9 main red two after", int'(mainLight), RED);
      chk("R9 side red two after", int'(sideLight), RED);
      step();
      chk("R9 main red three after", int'(mainLight), RED);
      step();
      chk("R9 main red four after", int'(mainLight), RED);
      n = 0;
      while (sideLight != LT_GREEN && n < 30) begin
        step();
        n++;
      end
      chk("R11 recovery green within bound", int'(n <= 11), 1);
    end

    chk("R10 no exclusion violation", exclViol, 0);
    chk("R4 yellow always to red", yellowViol, 0);
    chk("R11 max wait bound", int'(maxWait <= 11), 1);

    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule